// File: doc/BRIEF.md
# Interlocked Pipeline Stall Controller

This block decides when a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) with no operand forwarding must stall. Each cycle it looks at the instruction in decode and compares that instruction's source registers with the destination registers of the older instructions in the execute and memory stages. A source may only be read from the register file. The register file is written in the first half of a cycle and read in the second half, so an instruction can read a result in the same cycle that its producer writes it back.

When a pending write conflicts with a read in decode, the block raises `stall` and `bubble` together. `stall` holds the program counter and the fetch/decode register, which freezes both the decode instruction and the instruction behind it in fetch. `bubble` puts a nop into execute. That nop never writes a register, so it takes part in no later comparison. The stall length follows from how far ahead the producer is. A producer directly ahead costs two cycles. A producer two ahead costs one cycle. Decoding, the register file and the datapath are outside the block.

Top module: `stall_ctl`

## Requirements
- R1: While `rst` is high at a rising edge, and until the first rising edge with `rst` low, `stall` and `bubble` are 0.
- R2: `stall` is 1 when a valid nonzero decode source equals `ex_dst` and `ex_wen` is 1.
- R3: `stall` is 1 when a valid nonzero decode source equals `mem_dst` and `mem_wen` is 1.
- R4: A source whose valid bit is 0 never causes a stall. An immediate operand or an absent operand is presented this way.
- R5: Register number 0 never causes a stall, even when it matches a destination that has its write-enable set.
- R6: A stage with its write-enable at 0, such as a store, a nop or an empty slot, never causes a stall. A producer that has reached writeback causes no stall.
- R7: `bubble` equals `stall` in every cycle.
- R8: A consumer directly behind its producer is stalled for exactly two consecutive cycles. A consumer two behind its producer is stalled for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_rs_valid | input | 1 | First decode source is a register |
| id_rs | input | REG_W | First decode source register number |
| id_rt_valid | input | 1 | Second decode source is a register |
| id_rt | input | REG_W | Second decode source register number |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_W | Execute-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Inject a nop into execute |

## Verification
Two functions can fall in the same cycle: a match against the execute stage and a match against the memory stage. This happens when both sources hit, or when both stages write the register that decode reads. The sweep covers every combination of both stage matches with both sources over a small set of register numbers. Each result is judged against the rule that any single qualifying match stalls, and that overlapping matches still give one stall and one bubble, never anything else. Two short pipeline sequences then advance a producer stage by stage, with the bubble taking its place. In these sequences the bench counts the stall cycles: two when the producer is directly ahead, one when it is two ahead.

// File: rtl/stall_ctl.sv
module stall_ctl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_rs_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic             id_rt_valid,
  input  logic [REG_W-1:0] id_rt,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  output logic             stall,
  output logic             bubble
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  wire rs_live = id_rs_valid && (id_rs != ZERO_REG);
  wire rt_live = id_rt_valid && (id_rt != ZERO_REG);

  wire ex_hit  = ex_wen  && ((rs_live && id_rs == ex_dst)  || (rt_live && id_rt == ex_dst));
  wire mem_hit = mem_wen && ((rs_live && id_rs == mem_dst) || (rt_live && id_rt == mem_dst));

  assign stall  = run_q && (ex_hit || mem_hit);
  assign bubble = stall;
endmodule

// File: rtl/stall_ctl_chk.sv
module stall_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             id_rs_valid,
  input logic [REG_W-1:0] id_rs,
  input logic             id_rt_valid,
  input logic [REG_W-1:0] id_rt,
  input logic             ex_wen,
  input logic [REG_W-1:0] ex_dst,
  input logic             mem_wen,
  input logic [REG_W-1:0] mem_dst,
  input logic             stall,
  input logic             bubble
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_quiet_after_reset_R1: assert (!stall && !bubble);
    end
  end

  assert_same_R7: assert property (@(posedge clk) disable iff (rst)
    stall == bubble);

  assert_no_src_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (!id_rs_valid && !id_rt_valid) |-> !stall);

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (rst)
    ((id_rs == '0 || !id_rs_valid) && (id_rt == '0 || !id_rt_valid)) |-> !stall);

  assert_no_writer_R6: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen) |-> !stall);

  assert_ex_match_R2: assert property (@(posedge clk) disable iff (rst || rst_d)
    (ex_wen && id_rs_valid && id_rs != '0 && id_rs == ex_dst) |-> stall);

  assert_mem_match_R3: assert property (@(posedge clk) disable iff (rst || rst_d)
    (mem_wen && id_rt_valid && id_rt != '0 && id_rt == mem_dst) |-> stall);
endmodule

bind stall_ctl stall_ctl_chk #(.REG_W(REG_W)) chk (.*);

// File: tb/tb_stall_ctl.sv
module tb_stall_ctl;
  localparam int W = 5;
  logic clk = 0, rst = 1;
  logic rsv, rtv, exw, mew;
  logic [W-1:0] rs, rt, exd, med;
  logic stall, bubble;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  stall_ctl #(.REG_W(W)) dut (
    .clk(clk), .rst(rst), .id_rs_valid(rsv), .id_rs(rs), .id_rt_valid(rtv), .id_rt(rt),
    .ex_wen(exw), .ex_dst(exd), .mem_wen(mew), .mem_dst(med), .stall(stall), .bubble(bubble));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (rs=%0d/%b rt=%0d/%b ex=%0d/%b mem=%0d/%b)",
               req, act, exp, rs, rsv, rt, rtv, exd, exw, med, mew);
    end
  endtask

  task automatic drive(input logic a, input int b, input logic c, input int d,
                       input logic e, input int f, input logic g, input int h);
    rsv = a; rs = W'(b); rtv = c; rt = W'(d); exw = e; exd = W'(f); mew = g; med = W'(h);
  endtask

  function automatic logic model(input logic a, input int b, input logic c, input int d,
                                 input logic e, input int f, input logic g, input int h);
    logic r = 0;
    if (a && b != 0 && e && b == f) r = 1;
    if (c && d != 0 && e && d == f) r = 1;
    if (a && b != 0 && g && b == h) r = 1;
    if (c && d != 0 && g && d == h) r = 1;
    return r;
  endfunction

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    drive(1, 3, 1, 3, 1, 3, 1, 3);
    repeat (3) @(negedge clk);
    check("R1 stall in reset", stall, 0);
    check("R1 bubble in reset", bubble, 0);
    rst = 0;
    #1;
    check("R1 before first edge after reset", stall, 0);
    @(negedge clk); #1;
    check("R2 live after reset", stall, 1);

    for (int a = 0; a < 2; a++)
    for (int b = 0; b < 4; b++)
    for (int c = 0; c < 2; c++)
    for (int d = 0; d < 4; d++)
    for (int e = 0; e < 2; e++)
    for (int f = 0; f < 4; f++)
    for (int g = 0; g < 2; g++)
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      drive(a[0], b, c[0], d, e[0], f, g[0], h);
      #1;
      check("R2/R3/R4/R5/R6 sweep", stall, model(a[0], b, c[0], d, e[0], f, g[0], h));
      check("R7 bubble", bubble, stall);
    end

    @(negedge clk); drive(0, 7, 1, 7, 1, 7, 0, 0); #1; check("R4 only rt valid, EX", stall, 1);
    @(negedge clk); drive(0, 9, 0, 9, 1, 9, 1, 9); #1; check("R4 immediate ignored", stall, 0);
    @(negedge clk); drive(1, 0, 1, 0, 1, 0, 1, 0); #1; check("R5 zero register", stall, 0);
    @(negedge clk); drive(1, 31, 0, 0, 0, 0, 1, 31); #1; check("R3 top register in MEM", stall, 1);

    // R8: producer directly ahead -> EX, then bubble in EX/producer in MEM, then WB
    n = 0;
    @(negedge clk); drive(1, 10, 1, 12, 1, 10, 0, 0); #1; n += int'(stall);
    @(negedge clk); drive(1, 10, 1, 12, 0, 0, 1, 10); #1; n += int'(stall);
    @(negedge clk); drive(1, 10, 1, 12, 0, 0, 0, 0);  #1; n += int'(stall);
    check("R8 distance one stalls two", n == 2, 1);

    // R8: producer two ahead -> starts in MEM with an unrelated writer in EX
    n = 0;
    @(negedge clk); drive(1, 10, 1, 12, 1, 4, 1, 12); #1; n += int'(stall);
    @(negedge clk); drive(1, 10, 1, 12, 0, 0, 1, 4);  #1; n += int'(stall);
    check("R8 distance two stalls one", n == 1, 1);

    @(negedge clk); rst = 1; drive(1, 5, 0, 0, 1, 5, 0, 0);
    @(negedge clk); #1;
    check("R1 reset reasserted", stall, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule